// File: doc/BRIEF.md
# Double-Buffered PWM Channel with Power-of-Two Prescaler

This block produces one pulse-width-modulated output from a slow reference tick, a single-cycle strobe at 1 MHz sampled in the `clk` domain. A small write port stages three settings: a control word, a duty count and a period count. The control word holds a 2-bit divide code and a polarity bit. The staged settings do not touch the running waveform. A write to the period register arms an update. The block applies all staged settings together at the next period boundary. Every period therefore runs entirely on the old settings or entirely on the new ones.

Software writes the control word, then the duty count, then the period count. Clearing `run_en` lets the current period run to its end, and the output then stays low. Raising `run_en` while the channel is idle loads the staged settings at once and starts counting from zero. A staged period of zero keeps the channel idle.

Top module: `pwm_shadow_chan`

## Requirements
- R1: After reset the channel is idle, `pwm_out` is 0, every staged setting is zero and no update is armed.
- R2: The divide code is control bits [1:0]. Code 0 divides by 1, code 1 by 2, code 2 by 4 and code 3 by 8. The period counter advances once per that many `ref_tick` strobes, and a period lasts period × ratio strobes.
- R3: With control bit 2 clear, `pwm_out` is high while the period counter is below the duty count and low for the rest of the period. Duty 0 gives a constant low. Duty at or above the period gives a constant high.
- R4: With control bit 2 set, the running output is the inverse of the R3 level.
- R5: A write to the control word (`wr_sel`=0) or the duty count (`wr_sel`=1) changes neither the running waveform nor the arming of an update.
- R6: A write to the period count (`wr_sel`=2) arms an update. At the next period boundary all three staged values become active in the same cycle, and the counter and prescaler restart from zero.
- R7: When `run_en` is low at a period boundary, the channel goes idle and holds `pwm_out` low for as long as `run_en` stays low. A period that is already running always completes.
- R8: A period count of zero acts as disabled. The channel does not start from idle with it. If such a value is applied at a boundary, the channel goes idle with the output low.
- R9: When `run_en` is high while the channel is idle and the staged period is nonzero, the staged values load on the next clock edge, with or without an armed update, and counting starts from zero.
- R10: A write with `wr_sel`=3 changes no setting and arms nothing.
- R11: A period write on the same edge as a period's final tick does not update that boundary. It arms the update for the following boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe of the 1 MHz reference |
| run_en | input | 1 | Channel enable; a drop takes effect at a period boundary |
| wr_en | input | 1 | Write strobe for the staging registers |
| wr_sel | input | 2 | 0 control, 1 duty, 2 period (arms update), 3 no register |
| wr_data | input | CNT_W | Write data; control uses bits [1:0] divide code and bit 2 polarity |
| pwm_out | output | 1 | Modulated output |

## Verification
The bench sweeps every divide code and both polarities over several periods. It pairs each with duty values of zero, one, period minus one, equal to the period and above the period, and compares `pwm_out` cycle by cycle against an arithmetic model that counts strobes. A design that applied staged values before the boundary would show a mixed period right after the control or duty write. A design that let a bare control or duty write arm an update would change the waveform in the R5 phase. The bench places a period write exactly on a final tick, where a design with the wrong order of set and clear would commit early or never commit. It also covers the disable, zero-period and sparse-strobe cases, where a wrong design cuts the period short, leaves the output high, or counts clock cycles instead of strobes.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_DUTY = 2'd1,
    SEL_PER  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } chan_state_e;

  // divide ratio selected by a prescaler code: 2**code
  function automatic int unsigned psc_ratio(input int unsigned code);
    return 32'd1 << code;
  endfunction

  // width of a counter that must reach the largest ratio minus one
  function automatic int unsigned psc_cnt_width(input int unsigned code_w);
    int unsigned max_ratio;
    max_ratio = 32'd1 << ((32'd1 << code_w) - 1);
    return (max_ratio > 1) ? $clog2(max_ratio) : 1;
  endfunction

  // waveform level before the channel gate
  function automatic logic wave_level(input int unsigned cnt,
                                      input int unsigned duty,
                                      input logic        inv);
    return (cnt < duty) ^ inv;
  endfunction

endpackage

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             clr_arm,
  output logic [PSC_W-1:0] sh_psc,
  output logic             sh_pol,
  output logic [CNT_W-1:0] sh_duty,
  output logic [CNT_W-1:0] sh_per,
  output logic             armed,
  output logic             per_wr
);

  logic ctrl_wr;
  logic duty_wr;
  logic none_wr;

  assign ctrl_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_CTRL);
  assign duty_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_DUTY);
  assign per_wr  = wr_en && (reg_sel_e'(wr_sel) == SEL_PER);
  assign none_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_psc  <= '0;
      sh_pol  <= 1'b0;
      sh_duty <= '0;
      sh_per  <= '0;
    end else begin
      if (ctrl_wr) begin
        sh_psc <= wr_data[PSC_W-1:0];
        sh_pol <= wr_data[PSC_W];
      end
      if (duty_wr) sh_duty <= wr_data;
      if (per_wr)  sh_per  <= wr_data;
    end
  end

  // a period write wins over a same-edge clear, so it arms the next boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed <= 1'b0;
    else if (per_wr)  armed <= 1'b1;
    else if (clr_arm) armed <= 1'b0;
  end

  // R5: arming only ever follows a period write
  a_r5_arm_by_period_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(per_wr));

  // R10: a write to the unused select leaves every staged value alone
  a_r10_none_sel_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    none_wr |=> ($stable(sh_per) && $stable(sh_duty) && $stable(sh_psc) && $stable(sh_pol)));

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_chan_pkg::*;
#(
  parameter int PSC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             ref_tick,
  input  logic [PSC_W-1:0] psc_code,
  output logic             cnt_tick
);

  localparam int PCW = psc_cnt_width(PSC_W);

  logic [PCW-1:0] psc_cnt;
  logic [PCW-1:0] psc_last;

  assign psc_last = PCW'(psc_ratio(32'(psc_code)) - 1);
  assign cnt_tick = run && ref_tick && (psc_cnt == psc_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                psc_cnt <= '0;
    else if (restart || !run)  psc_cnt <= '0;
    else if (cnt_tick)         psc_cnt <= '0;
    else if (ref_tick)         psc_cnt <= psc_cnt + 1'b1;
  end

  // R2: the strobe divider never passes ratio minus one
  a_r2_psc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    psc_cnt <= psc_last);

  // R2: with no strobe the divider holds unless restarted
  a_r2_psc_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ref_tick && !restart) |=> $stable(psc_cnt));

endmodule

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             cnt_tick,
  input  logic [CNT_W-1:0] per,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  assign wrap = cnt_tick && (cnt == per - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (restart)  cnt <= '0;
    else if (wrap)     cnt <= '0;
    else if (cnt_tick) cnt <= cnt + 1'b1;
  end

  // R2: the period counter only moves on a divided tick or a restart
  a_r2_cnt_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> $past(cnt_tick || restart));

endmodule

// File: rtl/pwm_shadow_chan.sv
module pwm_shadow_chan
  import pwm_chan_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             run_en,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic             pwm_out
);

  // staged values
  logic [PSC_W-1:0] sh_psc;
  logic             sh_pol;
  logic [CNT_W-1:0] sh_duty;
  logic [CNT_W-1:0] sh_per;
  logic             armed;
  logic             per_wr;

  // active values
  logic [PSC_W-1:0] act_psc;
  logic             act_pol;
  logic [CNT_W-1:0] act_duty;
  logic [CNT_W-1:0] act_per;

  chan_state_e      state;
  logic             in_run;
  logic             cnt_tick;
  logic [CNT_W-1:0] cnt;
  logic             wrap;

  // named events
  logic             load_start;
  logic             boundary;
  logic             commit;
  logic             do_load;
  logic             go_idle;

  pwm_shadow_regs #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .clr_arm (do_load),
    .sh_psc  (sh_psc),
    .sh_pol  (sh_pol),
    .sh_duty (sh_duty),
    .sh_per  (sh_per),
    .armed   (armed),
    .per_wr  (per_wr)
  );

  pwm_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (in_run),
    .restart  (do_load),
    .ref_tick (ref_tick),
    .psc_code (act_psc),
    .cnt_tick (cnt_tick)
  );

  pwm_period_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (do_load),
    .cnt_tick (cnt_tick),
    .per      (act_per),
    .cnt      (cnt),
    .wrap     (wrap)
  );

  assign in_run     = (state == ST_RUN);
  assign load_start = !in_run && run_en && (sh_per != '0);
  assign boundary   = in_run && wrap;
  assign commit     = boundary && run_en && armed;
  assign do_load    = load_start || commit;
  assign go_idle    = boundary && (!run_en || (armed && (sh_per == '0)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (load_start) state <= ST_RUN;
        ST_RUN:  if (go_idle)    state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_psc  <= '0;
      act_pol  <= 1'b0;
      act_duty <= '0;
      act_per  <= '0;
    end else if (do_load) begin
      act_psc  <= sh_psc;
      act_pol  <= sh_pol;
      act_duty <= sh_duty;
      act_per  <= sh_per;
    end
  end

  assign pwm_out = in_run && wave_level(32'(cnt), 32'(act_duty), act_pol);

  // R6: active settings change only on a load event
  a_r6_active_on_load_only: assert property (@(posedge clk) disable iff (!rst_n)
    ((act_per != $past(act_per)) || (act_duty != $past(act_duty)) ||
     (act_pol != $past(act_pol)) || (act_psc != $past(act_psc))) |-> $past(do_load));

  // R7: running stops only at a period boundary
  a_r7_stop_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_run) && !in_run) |-> $past(boundary));

  // R8: the channel never runs with a zero period
  a_r8_no_zero_period_run: assert property (@(posedge clk) disable iff (!rst_n)
    in_run |-> (act_per != '0));

  // R3: the counter stays inside the active period
  a_r3_cnt_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    in_run |-> (cnt < act_per));

  // R7: idle output is low
  a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_run && !$past(in_run)) |-> !pwm_out);

endmodule

// File: tb/sim_pwm_shadow_chan.sv
module sim_pwm_shadow_chan;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ref_tick;
  logic        run_en;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [15:0] wr_data;
  logic        pwm_out;

  always #5 clk = ~clk;

  pwm_shadow_chan #(.CNT_W(16), .PSC_W(2)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .run_en(run_en),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .pwm_out(pwm_out)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  int    ph_err = 0;
  string ph_tag = "";
  int    cyc_no = 0;
  int    tick_mode = 0;
  bit    done = 0;

  // reference model state
  bit m_run = 0;
  int m_t = 0;
  bit m_armed = 0;
  int s_psc = 0, s_pol = 0, s_duty = 0, s_per = 0;
  int a_psc = 0, a_pol = 0, a_duty = 0, a_per = 0;

  function automatic logic exp_out();
    logic lvl;
    lvl = ((m_t / (1 << a_psc)) < a_duty);
    return m_run & (lvl ^ a_pol[0]);
  endfunction

  function automatic void m_load();
    a_psc = s_psc; a_pol = s_pol; a_duty = s_duty; a_per = s_per;
    m_armed = 0;
    m_t = 0;
    if (a_per == 0) m_run = 0;
  endfunction

  function automatic void model_edge(input bit tk, input bit we,
                                     input logic [1:0] sel, input logic [15:0] d);
    if (m_run) begin
      if (tk) begin
        m_t++;
        if (m_t == (1 << a_psc) * a_per) begin
          m_t = 0;
          if (!run_en) m_run = 0;
          else if (m_armed) m_load();
        end
      end
    end else if (run_en && s_per != 0) begin
      m_run = 1;
      m_load();
    end
    if (we) begin
      case (sel)
        2'd0: begin s_psc = int'(d[1:0]); s_pol = int'(d[2]); end
        2'd1: s_duty = int'(d);
        2'd2: begin s_per = int'(d); m_armed = 1; end
        default: ;
      endcase
    end
  endfunction

  task automatic cyc(input bit we, input logic [1:0] sel, input logic [15:0] d);
    logic e;
    bit   tk;
    e = exp_out();
    if (pwm_out !== e) begin
      if (ph_err == 0)
        $display("FAIL %s: cycle %0d pwm_out=%b expected=%b", ph_tag, cyc_no, pwm_out, e);
      ph_err++;
    end
    tk = (tick_mode == 0) ? 1'b1 : ((cyc_no % 3) == 0);
    ref_tick = tk;
    wr_en = we; wr_sel = sel; wr_data = d;
    model_edge(tk, we, sel, d);
    @(posedge clk);
    @(negedge clk);
    cyc_no++;
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 16'd0);
  endtask

  task automatic prog(input int ctrl, input int duty, input int per);
    cyc(1'b1, 2'd0, 16'(ctrl));
    cyc(1'b1, 2'd1, 16'(duty));
    cyc(1'b1, 2'd2, 16'(per));
  endtask

  task automatic begin_phase(input string tag);
    ph_tag = tag;
    ph_err = 0;
  endtask

  task automatic end_phase();
    n_chk++;
    if (ph_err != 0) n_fail++;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: cycle %0d run did not finish, expected completion", cyc_no);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ref_tick = 1'b0; run_en = 1'b0;
    wr_en = 1'b0; wr_sel = 2'd0; wr_data = 16'd0;
    repeat (3) @(negedge clk);
    // R1: reset state
    n_chk++;
    if (pwm_out !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: pwm_out=%b expected=0 in reset", pwm_out);
    end
    rst_n = 1'b1;

    begin_phase("R1 idle after reset");
    idle_n(10);
    end_phase();

    // R8: enabling with zero staged period stays idle
    begin_phase("R8 zero period start");
    run_en = 1'b1;
    idle_n(20);
    end_phase();

    // R9: staged values load at once when enabled from idle
    run_en = 1'b0;
    prog(32'h1, 2, 5);
    begin_phase("R9 start from idle");
    run_en = 1'b1;
    idle_n(40);
    end_phase();

    // R2 R3 R6: sweep divide codes and duty corners, normal polarity
    for (int pol = 0; pol < 2; pol++) begin
      begin_phase(pol == 0 ? "R2 R3 R6 sweep normal" : "R4 sweep inverted");
      for (int p = 0; p < 4; p++) begin
        for (int pi = 0; pi < 3; pi++) begin
          int per;
          per = 1 + 2 * pi;
          for (int di = 0; di < 5; di++) begin
            int duty;
            case (di)
              0: duty = 0;
              1: duty = 1;
              2: duty = per - 1;
              3: duty = per;
              default: duty = per + 2;
            endcase
            prog(p | (pol << 2), duty, per);
            idle_n(45 + 2 * (1 << p) * per);
          end
        end
      end
      end_phase();
    end

    // R5: control and duty writes alone never take effect
    prog(32'h1, 2, 6);
    idle_n(60);
    begin_phase("R5 no arm without period write");
    cyc(1'b1, 2'd0, 16'h7);
    cyc(1'b1, 2'd1, 16'd5);
    idle_n(80);
    end_phase();

    // R10: unused select is ignored
    begin_phase("R10 unused select");
    cyc(1'b1, 2'd3, 16'hFFFF);
    idle_n(80);
    end_phase();

    // R11: period write on the final tick arms the following boundary
    prog(32'h0, 1, 4);
    idle_n(20);
    begin_phase("R11 write on final tick");
    cyc(1'b1, 2'd1, 16'd3);
    while (!(m_run && (m_t + 1 == (1 << a_psc) * a_per))) cyc(1'b0, 2'd0, 16'd0);
    cyc(1'b1, 2'd2, 16'd6);
    idle_n(30);
    end_phase();

    // R2: sparse strobes
    begin_phase("R2 sparse strobes");
    tick_mode = 1;
    prog(32'h1, 2, 3);
    idle_n(200);
    tick_mode = 0;
    end_phase();

    // R7: disable mid-period finishes the period then holds low
    prog(32'h2, 3, 5);
    idle_n(50);
    begin_phase("R7 graceful disable");
    idle_n(7);
    run_en = 1'b0;
    idle_n(70);
    end_phase();

    // R9 again: restart after disable
    begin_phase("R9 restart");
    run_en = 1'b1;
    idle_n(30);
    end_phase();

    // R8: committing a zero period stops the channel
    begin_phase("R8 commit zero period");
    cyc(1'b1, 2'd2, 16'd0);
    idle_n(60);
    end_phase();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule